// File: doc/BRIEF.md
# Reed-Solomon Parity Engine Front End

This block is the register-facing control and parity path of a flash-page error-correction engine. Software programs a small control word, streams the data bytes of one 512-byte block through a byte port, and the engine folds those bytes into 9-bit symbols. It then computes eight parity symbols of a systematic Reed-Solomon code over GF(2^9). The 72 parity bits are exposed as nine bytes in three 32-bit words, and a status word reports when padding and encoding have completed.

For reads, software loads the nine stored parity bytes into the same words and raises a parity-ready control bit in decode mode. The engine then reports decode completion. Error location is handled by a later stage that is not part of this block, so the decode path always reports zero errors. A reset bit in the control word restarts the engine before each block.

Top module: `rs_ecc_ctl`

## Requirements
- R1: After rst_n, the control word (address 0), the status word (address 1) and the parity words (addresses 2, 3, 4) all read zero.
- R2: In the control word, bit0 is enable, bit2 selects Reed-Solomon operation, bit3 selects encode (1) or decode (0), and bit4 is parity-ready. These bits read back as written. Bit1 (engine reset) always reads 0, and bits 31:5 read 0. Control writes take effect only when byte lane 0 is enabled.
- R3: After a full block, the parity bytes hold the remainder of m(x)*x^8 modulo g(x) = (x-a^0)...(x-a^7) over GF(2^9) with the field polynomial x^9+x^4+1. The data bits are packed LSB-first, so byte b bit i is stream bit 8b+i, and symbol s is stream bits 9s..9s+8. Symbol 0 is the highest-degree coefficient, and the last symbol is padded with zeros. The coefficient of x^j occupies bits 9j..9j+8 of a 72-bit vector. Byte k of that vector is at word 2+k/4, lane k%4.
- R4: The status word has bit0 error, bit1 uncorrectable, bit2 encode done, bit3 decode done, bit4 padding done, and bits 31:29 error count. Padding done is set at the first clock edge after the edge that absorbs the 512th byte. Encode done is set at the edge after that.
- R5: A data byte is absorbed only while enable, Reed-Solomon select and encode are all set, and only until the block is full. Other bytes leave the parity unchanged.
- R6: A control write with bit1 set discards the partly absorbed block, returns the engine to accepting a fresh block, and clears parity-ready.
- R7: Writing 0x00000000 to the status word clears every status bit. Writing any non-zero value to it leaves the status unchanged.
- R8: Each parity byte is writable on its own through the byte-lane enables. Lanes beyond the ninth byte read zero.
- R9: A control write with enable=1, select=1, encode=0 and parity-ready=1 starts a check. Decode done is set one edge after that write, with the error bits and the error count at zero. The check leaves the parity bytes unchanged.
- R10: Setting parity-ready while encode is set or enable is clear does not set decode done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_be_i | input | 4 | Byte-lane enables for the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| dat_vld_i | input | 1 | A data byte is presented this cycle |
| dat_i | input | 8 | Data byte |

## Verification
The bench compares the parity of random blocks and of an all-0xFF block against a long-division model. A wrong bit order or a wrong symbol degree would give different parity bytes. It inserts bytes while the engine is disabled, in non-RS mode and after the block is full. A design that absorbs them would show shifted parity. It checks the padding and encode-done timing to the exact edge, so a missed pad symbol or a late flag is reported. It also checks that a mid-block engine reset discards earlier bytes and clears parity-ready, and that parity-ready set in encode mode or with the engine disabled never produces decode done.

// File: rtl/rs_ctl_pkg.sv
package rs_ctl_pkg;

    localparam int SYM_W = 9;
    localparam int NPAR  = 8;

    typedef enum logic [2:0] {
        ST_COLLECT = 3'd0,
        ST_PAD     = 3'd1,
        ST_FIN     = 3'd2,
        ST_CHECK   = 3'd3,
        ST_DONE    = 3'd4
    } eng_state_e;

    // GF(2^SYM_W) multiply; poly_low holds the field polynomial minus x^SYM_W
    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b,
                                                input logic [SYM_W-1:0] poly_low);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc ^= x;
            x = x[SYM_W-1] ? ({x[SYM_W-2:0], 1'b0} ^ poly_low) : {x[SYM_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    // generator polynomial with roots alpha^0 .. alpha^(NPAR-1), monic
    function automatic logic [NPAR:0][SYM_W-1:0] gen_poly(input logic [SYM_W-1:0] poly_low);
        logic [NPAR:0][SYM_W-1:0] g;
        logic [SYM_W-1:0]         root;
        g    = '0;
        g[0] = SYM_W'(1);
        root = SYM_W'(1);
        for (int i = 0; i < NPAR; i++) begin
            for (int j = NPAR; j > 0; j--)
                g[j] = g[j-1] ^ gf_mul(g[j], root, poly_low);
            g[0] = gf_mul(g[0], root, poly_low);
            root = gf_mul(root, SYM_W'(2), poly_low);
        end
        return g;
    endfunction

endpackage

// File: rtl/rs_sym_packer.sv
module rs_sym_packer
    import rs_ctl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              flush_i,
    output logic              sym_vld_o,
    output logic [SYM_W-1:0]  sym_o
);

    localparam int CNT_W = $clog2(SYM_W + BYTE_W + 1);
    localparam int MW    = 2 * SYM_W - 1;

    typedef struct packed {
        logic [SYM_W-2:0] acc;
        logic [CNT_W-1:0] cnt;
    } pk_t;

    pk_t q, d;
    logic [MW-1:0]    merged;
    logic [CNT_W-1:0] sum;

    always_comb begin
        d         = q;
        sym_vld_o = 1'b0;
        sym_o     = '0;
        merged    = MW'(q.acc) | (MW'(byte_i) << q.cnt);
        sum       = q.cnt + CNT_W'(BYTE_W);
        if (clr_i) begin
            d = '0;
        end else if (flush_i) begin
            sym_vld_o = (q.cnt != '0);
            sym_o     = SYM_W'(q.acc);
            d         = '0;
        end else if (byte_vld_i) begin
            if (sum >= CNT_W'(SYM_W)) begin
                sym_vld_o = 1'b1;
                sym_o     = merged[SYM_W-1:0];
                d.acc     = merged[SYM_W +: SYM_W-1];
                d.cnt     = sum - CNT_W'(SYM_W);
            end else begin
                d.acc = merged[SYM_W-2:0];
                d.cnt = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: leftover bits never make a complete symbol
    assert_residual_lt_sym_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(SYM_W));

endmodule

// File: rtl/rs_par_lfsr.sv
module rs_par_lfsr
    import rs_ctl_pkg::*;
#(
    parameter logic [SYM_W-1:0] PRIM_LOW = 9'h011
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    sym_vld_i,
    input  logic [SYM_W-1:0]        sym_i,
    output logic [NPAR*SYM_W-1:0]   par_o
);

    localparam logic [NPAR:0][SYM_W-1:0] GEN = gen_poly(PRIM_LOW);

    typedef struct packed {
        logic [NPAR-1:0][SYM_W-1:0] r;
    } lfsr_t;

    lfsr_t q, d;
    logic [SYM_W-1:0]           fb;
    logic [NPAR-1:0][SYM_W-1:0] prod;

    assign fb = sym_i ^ q.r[NPAR-1];

    for (genvar j = 0; j < NPAR; j++) begin : g_mul
        assign prod[j] = gf_mul(fb, GEN[j], PRIM_LOW);
    end

    always_comb begin
        d = q;
        if (clr_i) begin
            d.r = '0;
        end else if (sym_vld_i) begin
            d.r[0] = prod[0];
            for (int j = 1; j < NPAR; j++)
                d.r[j] = q.r[j-1] ^ prod[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign par_o = q.r;

    // R6: a clear leaves an all-zero remainder
    assert_clr_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (par_o == '0));

endmodule

// File: rtl/rs_ecc_ctl.sv
module rs_ecc_ctl
    import rs_ctl_pkg::*;
#(
    parameter int               BLK_BYTES = 512,
    parameter logic [SYM_W-1:0] PRIM_LOW  = 9'h011,
    parameter int               ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [3:0]        reg_be_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              dat_vld_i,
    input  logic [7:0]        dat_i
);

    localparam int PAR_BITS  = NPAR * SYM_W;
    localparam int PAR_BYTES = (PAR_BITS + 7) / 8;
    localparam int BCNT_W    = $clog2(BLK_BYTES + 1);
    localparam int A_CTRL    = 0;
    localparam int A_STAT    = 1;
    localparam int A_PAR0    = 2;

    typedef struct packed {
        logic                       en;
        logic                       rs;
        logic                       enc;
        logic                       prdy;
        logic                       st_err;
        logic                       st_uncor;
        logic                       st_enc;
        logic                       st_dec;
        logic                       st_pad;
        logic [2:0]                 st_cnt;
        eng_state_e                 fsm;
        logic [BCNT_W-1:0]          bcnt;
        logic [PAR_BYTES-1:0][7:0]  par;
    } regs_t;

    regs_t q, d;

    logic                  soft_clr, dec_go, accept, pk_flush, ctrl_wr;
    logic                  pk_sym_vld;
    logic [SYM_W-1:0]      pk_sym;
    logic [PAR_BITS-1:0]   lfsr_par;
    logic [PAR_BYTES*8-1:0] par_ext;

    assign par_ext = (PAR_BYTES*8)'(lfsr_par);
    assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_W'(A_CTRL)) && reg_be_i[0];
    assign accept  = dat_vld_i && q.en && q.rs && q.enc && (q.fsm == ST_COLLECT);

    always_comb begin
        d        = q;
        soft_clr = 1'b0;
        dec_go   = 1'b0;
        pk_flush = 1'b0;

        // status clear by a zero write; engine updates below take priority
        if (reg_wr_i && (reg_addr_i == ADDR_W'(A_STAT)) && (reg_wdata_i == 32'd0)) begin
            d.st_err   = 1'b0;
            d.st_uncor = 1'b0;
            d.st_enc   = 1'b0;
            d.st_dec   = 1'b0;
            d.st_pad   = 1'b0;
            d.st_cnt   = '0;
        end

        for (int k = 0; k < PAR_BYTES; k++) begin
            if (reg_wr_i && (reg_addr_i == ADDR_W'(A_PAR0 + k / 4)) && reg_be_i[k % 4])
                d.par[k] = reg_wdata_i[8*(k%4) +: 8];
        end

        if (ctrl_wr) begin
            d.en  = reg_wdata_i[0];
            d.rs  = reg_wdata_i[2];
            d.enc = reg_wdata_i[3];
            if (reg_wdata_i[1]) begin
                soft_clr = 1'b1;
                d.prdy   = 1'b0;
            end else begin
                d.prdy = reg_wdata_i[4];
                dec_go = reg_wdata_i[4] && reg_wdata_i[0] && reg_wdata_i[2] && !reg_wdata_i[3];
            end
        end

        if (soft_clr) begin
            d.fsm  = ST_COLLECT;
            d.bcnt = '0;
        end else begin
            unique case (q.fsm)
                ST_COLLECT: begin
                    if (dec_go) begin
                        d.fsm = ST_CHECK;
                    end else if (accept) begin
                        d.bcnt = q.bcnt + BCNT_W'(1);
                        if (q.bcnt == BCNT_W'(BLK_BYTES - 1)) d.fsm = ST_PAD;
                    end
                end
                ST_PAD: begin
                    pk_flush = 1'b1;
                    d.st_pad = 1'b1;
                    d.fsm    = ST_FIN;
                end
                ST_FIN: begin
                    d.par    = par_ext;
                    d.st_enc = 1'b1;
                    d.fsm    = ST_DONE;
                end
                ST_CHECK: begin
                    d.st_dec   = 1'b1;
                    d.st_err   = 1'b0;
                    d.st_uncor = 1'b0;
                    d.st_cnt   = '0;
                    d.fsm      = ST_DONE;
                end
                default: d.fsm = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(A_CTRL))
            reg_rdata_o = {27'd0, q.prdy, q.enc, q.rs, 1'b0, q.en};
        else if (reg_addr_i == ADDR_W'(A_STAT))
            reg_rdata_o = {q.st_cnt, 24'd0, q.st_pad, q.st_dec, q.st_enc, q.st_uncor, q.st_err};
        for (int k = 0; k < PAR_BYTES; k++) begin
            if (reg_addr_i == ADDR_W'(A_PAR0 + k / 4))
                reg_rdata_o[8*(k%4) +: 8] = q.par[k];
        end
    end

    rs_sym_packer #(.BYTE_W(8)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (soft_clr),
        .byte_vld_i (accept && !soft_clr),
        .byte_i     (dat_i),
        .flush_i    (pk_flush),
        .sym_vld_o  (pk_sym_vld),
        .sym_o      (pk_sym)
    );

    rs_par_lfsr #(.PRIM_LOW(PRIM_LOW)) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (soft_clr),
        .sym_vld_i (pk_sym_vld),
        .sym_i     (pk_sym),
        .par_o     (lfsr_par)
    );

    // R4: encode done never appears without padding done in the cycle before
    assert_pad_then_enc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st_enc) |-> $past(q.st_pad));

    // R4: byte count never passes one block
    assert_bcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.bcnt <= BCNT_W'(BLK_BYTES));

    // R5: a symbol from the data path only while the encoder is armed
    assert_accept_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_sym_vld && !pk_flush) |-> (q.en && q.rs && q.enc));

    // R9: decode done follows the check state
    assert_dec_after_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st_dec) |-> $past(q.fsm == ST_CHECK));

endmodule

// File: tb/rs_ecc_ctl_bench.sv
`timescale 1ns/1ps
module rs_ecc_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dat_vld = 1'b0;
    logic [7:0]  dat = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  blk [0:511];
    logic [8:0]  gcoef [0:8];
    logic [71:0] pv;
    logic [31:0] v;

    always #2 clk = ~clk;

    rs_ecc_ctl u_rs_ecc_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_be_i(reg_be), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .dat_vld_i(dat_vld), .dat_i(dat)
    );

    function automatic logic [8:0] bmul(logic [8:0] a, logic [8:0] b);
        logic [17:0] p = '0;
        for (int i = 0; i < 9; i++) if (b[i]) p ^= (18'(a) << i);
        for (int i = 17; i >= 9; i--) if (p[i]) p ^= (18'h211 << (i - 9));
        return p[8:0];
    endfunction

    task automatic build_gen();
        logic [8:0] root = 9'd1;
        for (int j = 0; j < 9; j++) gcoef[j] = 9'd0;
        gcoef[0] = 9'd1;
        for (int i = 0; i < 8; i++) begin
            for (int j = 8; j > 0; j--) gcoef[j] = gcoef[j-1] ^ bmul(gcoef[j], root);
            gcoef[0] = bmul(gcoef[0], root);
            root = bmul(root, 9'd2);
        end
    endtask

    // long division of m(x)*x^8 by g(x)
    function automatic logic [71:0] ref_parity();
        logic [4103:0] bits = '0;
        logic [8:0] c [0:463];
        logic [8:0] coef;
        logic [71:0] r = '0;
        for (int b = 0; b < 512; b++) bits[8*b +: 8] = blk[b];
        for (int i = 0; i < 464; i++) c[i] = 9'd0;
        for (int s = 0; s < 456; s++) c[463 - s] = bits[9*s +: 9];
        for (int i = 463; i >= 8; i--) begin
            coef = c[i];
            if (coef != 9'd0)
                for (int j = 0; j <= 8; j++) c[i-8+j] ^= bmul(coef, gcoef[j]);
        end
        for (int j = 0; j < 8; j++) r[9*j +: 9] = c[j];
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] val);
        reg_addr = a;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] w);
        @(negedge clk);
        dat_vld = 1'b0;
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send_range(input int lo, input int hi, input bit gaps);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk);
            if (gaps) while ($urandom_range(3) == 0) begin dat_vld = 1'b0; @(negedge clk); end
            dat_vld = 1'b1; dat = blk[i];
        end
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dat_vld = 1'b1; dat = 8'($urandom);
        end
    endtask

    // ends a block stream and checks the padding and encode-done edges
    task automatic finish_block(string tag);
        @(negedge clk);
        dat_vld = 1'b0;
        rd(3'd1, v); check({tag, " R4 no flags at last-byte edge"}, v, 32'h0);
        @(negedge clk);
        rd(3'd1, v); check({tag, " R4 padding done one edge later"}, v, 32'h10);
        @(negedge clk);
        rd(3'd1, v); check({tag, " R4 encode done next edge"}, v, 32'h14);
    endtask

    task automatic check_parity(string tag);
        pv = ref_parity();
        rd(3'd2, v); check({tag, " R3 parity word 2"}, v, pv[31:0]);
        rd(3'd3, v); check({tag, " R3 parity word 3"}, v, pv[63:32]);
        rd(3'd4, v); check({tag, " R3 parity word 4"}, v, {24'd0, pv[71:64]});
    endtask

    task automatic fill_random();
        for (int i = 0; i < 512; i++) blk[i] = 8'($urandom);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        build_gen();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); check($sformatf("R1 reset word %0d", a), v, 32'h0);
        end

        // R2 control readback, R6 reset clears parity-ready
        wr(3'd0, 4'hF, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 R6 reset bit reads 0, parity-ready cleared", v, 32'h0000_000D);
        wr(3'd0, 4'hE, 32'h0000_0000);
        rd(3'd0, v); check("R2 write without lane 0 ignored", v, 32'h0000_000D);
        wr(3'd0, 4'h1, 32'hFFFF_FFF9);
        rd(3'd0, v); check("R2 upper bits read 0", v, 32'h0000_0019);
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R10 parity-ready in encode mode gives no decode", v, 32'h0);

        // R8 byte-lane parity writes
        wr(3'd2, 4'b0101, 32'hAABB_CCDD);
        rd(3'd2, v); check("R8 lanes 0 and 2 written", v, 32'h00BB_00DD);
        wr(3'd2, 4'b0010, 32'h0000_EE00);
        rd(3'd2, v); check("R8 lane 1 alone", v, 32'h00BB_EEDD);
        wr(3'd4, 4'hF, 32'h1234_5678);
        rd(3'd4, v); check("R8 lanes past byte 8 read 0", v, 32'h0000_0078);

        // block A: random, no gaps
        fill_random();
        wr(3'd0, 4'h1, 32'h0F);
        wr(3'd0, 4'h1, 32'h0D);
        wr(3'd1, 4'hF, 32'h0);
        send_range(0, 512, 1'b0);
        finish_block("A");
        check_parity("A");
        // R5 bytes after a full block are ignored
        send_junk(6);
        @(negedge clk); dat_vld = 1'b0;
        repeat (3) @(negedge clk);
        check_parity("A R5 after-block bytes");

        // R7 status clear rules
        wr(3'd1, 4'hF, 32'h0000_0001);
        rd(3'd1, v); check("R7 non-zero write keeps status", v, 32'h14);
        wr(3'd1, 4'hF, 32'h0);
        rd(3'd1, v); check("R7 zero write clears status", v, 32'h0);

        // block B: all ones, gaps, junk while disabled or not in RS mode
        for (int i = 0; i < 512; i++) blk[i] = 8'hFF;
        wr(3'd0, 4'h1, 32'h0F);
        wr(3'd0, 4'h1, 32'h0D);
        send_range(0, 256, 1'b1);
        wr(3'd0, 4'h1, 32'h0C);
        send_junk(4);
        wr(3'd0, 4'h1, 32'h09);
        send_junk(4);
        wr(3'd0, 4'h1, 32'h05);
        send_junk(4);
        wr(3'd0, 4'h1, 32'h0D);
        send_range(256, 512, 1'b1);
        finish_block("B");
        check_parity("B R5 gated bytes");

        // block C: R6 reset discards a partial block
        fill_random();
        wr(3'd1, 4'hF, 32'h0);
        wr(3'd0, 4'h1, 32'h0F);
        wr(3'd0, 4'h1, 32'h0D);
        send_junk(100);
        wr(3'd0, 4'h1, 32'h0F);
        wr(3'd0, 4'h1, 32'h0D);
        send_range(0, 512, 1'b1);
        finish_block("C");
        check_parity("C R6 after mid-block reset");

        // R9 decode check
        wr(3'd1, 4'hF, 32'h0);
        wr(3'd0, 4'h1, 32'h07);
        wr(3'd2, 4'hF, 32'h1357_9BDF);
        wr(3'd3, 4'hF, 32'h2468_ACE0);
        wr(3'd4, 4'h1, 32'h0000_0042);
        wr(3'd0, 4'h1, 32'h15);
        rd(3'd1, v); check("R9 no decode done at write edge", v, 32'h0);
        @(negedge clk);
        rd(3'd1, v); check("R9 decode done, zero errors", v, 32'h08);
        rd(3'd0, v); check("R2 parity-ready reads back", v, 32'h15);
        rd(3'd2, v); check("R9 parity word 2 kept", v, 32'h1357_9BDF);
        rd(3'd4, v); check("R9 parity word 4 kept", v, 32'h0000_0042);
        wr(3'd0, 4'h1, 32'h17);
        rd(3'd0, v); check("R6 reset clears parity-ready", v, 32'h05);

        // R10 parity-ready with enable clear
        wr(3'd1, 4'hF, 32'h0);
        wr(3'd0, 4'h1, 32'h14);
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R10 disabled parity-ready gives no decode", v, 32'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule